// File: doc/BRIEF.md
# Programmable Static Memory Strobe Sequencer

This block drives the control strobes of one external static or flash-style memory bank: chip select, output enable, write enable, an address-valid strobe, and the enables that put the address and the write data on the bus. The bank's timing comes from configuration inputs: the address-valid width, the output-enable lead, width and trail, and the write-enable lead and width. The sequencer copies these inputs at the start of each access and plays them out as a fixed series of phases. The length of an access comes only from these wait-state counts. The memory does not hand back a ready signal.

The host issues one access at a time over a valid/ready request channel. `req_ready` is high only while no access is in flight. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. The host may hold `req_valid` high for as long as it likes. The block gives back one `rsp_valid` pulse when the access is complete. The response cannot be stalled. For reads, the data comes with that pulse. A read can run asynchronously, or as a multiplexed synchronous read timed to the block clock. In the synchronous case a retiming option moves the data capture one clock later. The retiming option has no effect on asynchronous reads.

Top module: `smem_strobe_seq`

## Requirements
- R1: Out of reset, and whenever no access is in flight, `mem_cs_n`, `mem_adv_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_addr_oe` and `mem_dout_oe` are 0, and `req_ready` is 1.
- R2: `req_ready` is 1 only while idle. The cycle after an accepted request, `mem_cs_n` goes to 0. `mem_adv_n` is then 0 for `cfg_adv_width`+1 cycles while `mem_addr_oe` is 1 and `mem_addr` carries the request address.
- R3: After `mem_adv_n` returns to 1, the address stays driven for exactly one more cycle. `mem_addr_oe` is then 0 for the rest of the access.
- R4: For a read, `mem_oe_n` stays 1 for `cfg_oe_lead`+1 cycles after the address hold. It is then 0 for `cfg_oe_width`+1 cycles. It is then 1 for `cfg_oe_trail`+1 cycles with `mem_cs_n` still 0. `mem_oe_n` and `mem_we_n` are never both 0.
- R5: For a write, `mem_dout_oe` is 1 and `mem_dout` carries the write data from the cycle after the address hold up to the release of chip select. `mem_we_n` stays 1 for `cfg_we_lead`+1 cycles and is then 0 for `cfg_we_width`+1 cycles.
- R6: When `mem_we_n` returns to 1, chip select and write data stay valid for exactly one cycle, and then `mem_cs_n` goes to 1.
- R7: An asynchronous read (`cfg_sync`=0) samples `mem_din` on the clock edge that ends the last cycle in which `mem_oe_n` is 0.
- R8: A synchronous read with `cfg_retime`=1 samples `mem_din` one clock edge later than R7. `cfg_retime` has no effect when `cfg_sync`=0.
- R9: `rsp_valid` is 1 for exactly one cycle, the first cycle with `mem_cs_n` back at 1. `rsp_rdata` holds the read data in that cycle.
- R10: All `cfg_*` inputs are sampled at the accepting edge. Changes to them during an access do not affect that access.
- R11: A field value of 0 gives its phase exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data, valid with rsp_valid |
| cfg_sync | input | 1 | 1 = multiplexed synchronous read |
| cfg_retime | input | 1 | Late read capture, synchronous mode only |
| cfg_adv_width | input | FW | Address-valid pulse cycles minus one |
| cfg_oe_lead | input | FW | Cycles before OE, minus one |
| cfg_oe_width | input | FW | OE active cycles minus one |
| cfg_oe_trail | input | FW | Cycles after OE before release, minus one |
| cfg_we_lead | input | FW | Cycles before WE, minus one |
| cfg_we_width | input | FW | WE active cycles minus one |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | AW | Address bus value |
| mem_addr_oe | output | 1 | Address bus drive enable |
| mem_dout | output | DW | Write data bus value |
| mem_dout_oe | output | 1 | Write data drive enable |
| mem_din | input | DW | Read data from memory |

## Verification
The assertions look only at the strobes and the handshake. They assume that reset is applied before the first access and that `req_valid` is the only way an access starts. They make no assumption about how stable `mem_din` or the configuration inputs are, because the block latches the configuration at acceptance. The bench keeps the field values small, so that each access is short. It changes every configuration input right after acceptance, to show that the latched values are the ones that govern the access. It drives `mem_din` with a value that changes every cycle while chip select is active, so that the exact capture edge can be seen in the data.

// File: rtl/smss_pkg.sv
package smss_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_ADDR, PH_AHLD,
    PH_RSET, PH_RSTB, PH_RHLD,
    PH_WSET, PH_WSTB, PH_WHLD
  } phase_e;

  typedef struct packed {
    logic cs_n;
    logic adv_n;
    logic oe_n;
    logic we_n;
    logic addr_oe;
    logic dout_oe;
  } strobe_t;

  function automatic strobe_t phase_strobes(phase_e ph);
    strobe_t s;
    s.cs_n    = (ph == PH_IDLE);
    s.adv_n   = (ph != PH_ADDR);
    s.oe_n    = (ph != PH_RSTB);
    s.we_n    = (ph != PH_WSTB);
    s.addr_oe = (ph == PH_ADDR) || (ph == PH_AHLD);
    s.dout_oe = (ph == PH_WSET) || (ph == PH_WSTB) || (ph == PH_WHLD);
    return s;
  endfunction

endpackage

// File: rtl/smss_req_latch.sv
module smss_req_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/smss_phase_ctr.sv
module smss_phase_ctr #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] load_val,
  output logic          done
);
  logic [FW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/smss_rd_capture.sv
module smss_rd_capture #(
  parameter int DW        = 16,
  parameter bit RETIME_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_now,
  input  logic          retime,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rdata
);
  logic take;

  generate
    if (RETIME_EN) begin : g_rt
      logic cap_d;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_d <= 1'b0;
        else        cap_d <= cap_now;
      end
      assign take = retime ? cap_d : cap_now;
    end else begin : g_nrt
      assign take = retime ? cap_now : cap_now;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata <= '0;
    else if (take) rdata <= din;
  end
endmodule

// File: rtl/smem_strobe_seq.sv
module smem_strobe_seq
  import smss_pkg::*;
#(
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int FW        = 4,
  parameter bit RETIME_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic          cfg_sync,
  input  logic          cfg_retime,
  input  logic [FW-1:0] cfg_adv_width,
  input  logic [FW-1:0] cfg_oe_lead,
  input  logic [FW-1:0] cfg_oe_width,
  input  logic [FW-1:0] cfg_oe_trail,
  input  logic [FW-1:0] cfg_we_lead,
  input  logic [FW-1:0] cfg_we_width,
  output logic          mem_cs_n,
  output logic          mem_adv_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_addr_oe,
  output logic [DW-1:0] mem_dout,
  output logic          mem_dout_oe,
  input  logic [DW-1:0] mem_din
);

  typedef struct packed {
    logic          write;
    logic          sync;
    logic          retime;
    logic [FW-1:0] adv_width;
    logic [FW-1:0] oe_lead;
    logic [FW-1:0] oe_width;
    logic [FW-1:0] oe_trail;
    logic [FW-1:0] we_lead;
    logic [FW-1:0] we_width;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
  } acc_t;

  localparam int ACC_W = $bits(acc_t);

  phase_e        ph, ph_nxt;
  acc_t          acc_in, cur;
  logic          accept;
  logic          ld;
  logic [FW-1:0] ld_val;
  logic          ph_done;
  logic          finish;
  logic          cap_now;
  logic          retime_eff;
  strobe_t       stb;

  assign req_ready = (ph == PH_IDLE);
  assign accept    = req_valid && req_ready;

  assign acc_in = '{write:     req_write,
                    sync:      cfg_sync,
                    retime:    cfg_retime,
                    adv_width: cfg_adv_width,
                    oe_lead:   cfg_oe_lead,
                    oe_width:  cfg_oe_width,
                    oe_trail:  cfg_oe_trail,
                    we_lead:   cfg_we_lead,
                    we_width:  cfg_we_width,
                    addr:      req_addr,
                    wdata:     req_wdata};

  smss_req_latch #(.W(ACC_W)) u_latch (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept),
    .din  (acc_in),
    .dout (cur)
  );

  smss_phase_ctr #(.FW(FW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ld),
    .load_val(ld_val),
    .done    (ph_done)
  );

  always_comb begin
    ph_nxt = ph;
    ld     = 1'b0;
    ld_val = '0;
    finish = 1'b0;
    unique case (ph)
      PH_IDLE: if (req_valid) begin
        ph_nxt = PH_ADDR;
        ld     = 1'b1;
        ld_val = cfg_adv_width;
      end
      PH_ADDR: if (ph_done) begin
        ph_nxt = PH_AHLD;
        ld     = 1'b1;
      end
      PH_AHLD: begin
        ld = 1'b1;
        if (cur.write) begin
          ph_nxt = PH_WSET;
          ld_val = cur.we_lead;
        end else begin
          ph_nxt = PH_RSET;
          ld_val = cur.oe_lead;
        end
      end
      PH_RSET: if (ph_done) begin
        ph_nxt = PH_RSTB;
        ld     = 1'b1;
        ld_val = cur.oe_width;
      end
      PH_RSTB: if (ph_done) begin
        ph_nxt = PH_RHLD;
        ld     = 1'b1;
        ld_val = cur.oe_trail;
      end
      PH_RHLD: if (ph_done) begin
        ph_nxt = PH_IDLE;
        finish = 1'b1;
      end
      PH_WSET: if (ph_done) begin
        ph_nxt = PH_WSTB;
        ld     = 1'b1;
        ld_val = cur.we_width;
      end
      PH_WSTB: if (ph_done) begin
        ph_nxt = PH_WHLD;
        ld     = 1'b1;
      end
      PH_WHLD: begin
        ph_nxt = PH_IDLE;
        finish = 1'b1;
      end
      default: ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      rsp_valid <= 1'b0;
    end else begin
      ph        <= ph_nxt;
      rsp_valid <= finish;
    end
  end

  assign retime_eff = cur.sync && cur.retime;
  assign cap_now    = (ph == PH_RSTB) && ph_done;

  smss_rd_capture #(.DW(DW), .RETIME_EN(RETIME_EN)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_now(cap_now),
    .retime (retime_eff),
    .din    (mem_din),
    .rdata  (rsp_rdata)
  );

  assign stb         = phase_strobes(ph);
  assign mem_cs_n    = stb.cs_n;
  assign mem_adv_n   = stb.adv_n;
  assign mem_oe_n    = stb.oe_n;
  assign mem_we_n    = stb.we_n;
  assign mem_addr_oe = stb.addr_oe;
  assign mem_dout_oe = stb.dout_oe;
  assign mem_addr    = stb.addr_oe ? cur.addr  : '0;
  assign mem_dout    = stb.dout_oe ? cur.wdata : '0;

endmodule

// File: rtl/smem_strobe_seq_chk.sv
module smem_strobe_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic mem_cs_n,
  input logic mem_adv_n,
  input logic mem_oe_n,
  input logic mem_we_n,
  input logic mem_addr_oe,
  input logic mem_dout_oe
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_adv_n && mem_oe_n && mem_we_n && !mem_addr_oe && !mem_dout_oe)); // R1
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n); // R2
  AST_ADDR_HOLD_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_adv_n) && !mem_cs_n) |-> mem_addr_oe); // R3
  AST_ADDR_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_adv_n) && !mem_cs_n) |=> !mem_addr_oe); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R4
  AST_OE_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> (!mem_addr_oe && mem_adv_n)); // R4
  AST_WE_HOLD_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_cs_n && mem_dout_oe)); // R6
  AST_WE_HOLD_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> mem_cs_n); // R6
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9
  AST_RSP_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(mem_cs_n)); // R9
endmodule

bind smem_strobe_seq smem_strobe_seq_chk chk_i (.*);

// File: tb/smem_strobe_seq_tb_top.sv
module smem_strobe_seq_tb_top;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int FW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          cfg_sync = 1'b0, cfg_retime = 1'b0;
  logic [FW-1:0] cfg_adv_width = '0, cfg_oe_lead = '0, cfg_oe_width = '0;
  logic [FW-1:0] cfg_oe_trail = '0, cfg_we_lead = '0, cfg_we_width = '0;
  logic          mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, mem_addr_oe, mem_dout_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dout;
  logic [DW-1:0] mem_din;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // memory model: value changes every cycle chip select is active
  logic [DW-1:0] base = '0;
  int unsigned   cyc = 0;
  always @(posedge clk) cyc <= mem_cs_n ? 0 : cyc + 1;
  assign mem_din = base ^ DW'(cyc + 1);

  smem_strobe_seq #(.AW(AW), .DW(DW), .FW(FW)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected {adv_n, addr_oe, oe_n, we_n, dout_oe} in cycle i (1-based) of an access
  function automatic logic [4:0] exp_vec(int i, bit wr, int a, int l, int w);
    int p1 = a + 1;
    int p2 = p1 + 1;
    int p3 = p2 + l + 1;
    int p4 = p3 + w + 1;
    logic adv_n   = !(i <= p1);
    logic addr_oe = (i <= p2);
    logic strobe  = (i > p3) && (i <= p4);
    if (wr) return {adv_n, addr_oe, 1'b1, !strobe, (i > p2)};
    else    return {adv_n, addr_oe, !strobe, 1'b1, 1'b0};
  endfunction

  function automatic int acc_len(bit wr, int a, int l, int w, int t);
    return wr ? (a + l + w + 5) : (a + l + w + t + 5);
  endfunction

  task automatic do_access(input bit wr, input bit sy, input bit rt,
                           input int a, input int ol, input int ow, input int ot,
                           input int wl, input int ww,
                           input logic [AW-1:0] ad, input logic [DW-1:0] wd);
    int n, l, w, bad_adv, bad_oe, bad_we, bad_val, k;
    logic [4:0] got, exp;
    l = wr ? wl : ol;
    w = wr ? ww : ow;
    n = acc_len(wr, a, l, w, ot);
    bad_adv = 0; bad_oe = 0; bad_we = 0; bad_val = 0;
    @(negedge clk);
    base = ad[DW-1:0] ^ 16'h5A5A;
    req_valid = 1'b1; req_write = wr; req_addr = ad; req_wdata = wd;
    cfg_sync = sy; cfg_retime = rt;
    cfg_adv_width = FW'(a); cfg_oe_lead = FW'(ol); cfg_oe_width = FW'(ow);
    cfg_oe_trail = FW'(ot); cfg_we_lead = FW'(wl); cfg_we_width = FW'(ww);
    chk(req_ready === 1'b1 && mem_cs_n === 1'b1, "R2", "idle ready before request", req_ready, 1);
    @(posedge clk);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (i == 1) begin
        // R10: scramble every config input after acceptance
        req_valid = 1'b0; req_write = ~wr; req_addr = ~ad; req_wdata = ~wd;
        cfg_sync = ~sy; cfg_retime = ~rt;
        cfg_adv_width = ~FW'(a); cfg_oe_lead = ~FW'(ol); cfg_oe_width = ~FW'(ow);
        cfg_oe_trail = ~FW'(ot); cfg_we_lead = ~FW'(wl); cfg_we_width = ~FW'(ww);
      end
      got = {mem_adv_n, mem_addr_oe, mem_oe_n, mem_we_n, mem_dout_oe};
      exp = exp_vec(i, wr, a, l, w);
      if (got[4:3] !== exp[4:3]) bad_adv++;
      if (got[2] !== exp[2]) bad_oe++;
      if (got[1:0] !== exp[1:0]) bad_we++;
      if (mem_cs_n !== 1'b0 || rsp_valid !== 1'b0 || req_ready !== 1'b0) bad_val++;
      if (exp[3] && mem_addr !== ad) bad_val++;
      if (exp[0] && mem_dout !== wd) bad_val++;
    end
    chk(bad_adv == 0, "R2 R3 R10 R11", "adv/address cycles wrong", bad_adv, 0);
    chk(bad_oe == 0, "R4 R10 R11", "oe cycles wrong", bad_oe, 0);
    chk(bad_we == 0, "R5 R6 R10", "we/data cycles wrong", bad_we, 0);
    chk(bad_val == 0, "R2 R5 R9", "cs/bus values during access", bad_val, 0);
    @(negedge clk);
    chk(mem_cs_n === 1'b1 && rsp_valid === 1'b1, "R6 R9", "release and response",
        {mem_cs_n, rsp_valid}, 2'b11);
    if (!wr) begin
      k = a + ol + ow + 4 + ((sy && rt) ? 1 : 0);
      chk(rsp_rdata === (base ^ DW'(k)), (sy && rt) ? "R8" : "R7 R8",
          "read capture", rsp_rdata, base ^ DW'(k));
    end
    @(negedge clk);
    chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R9 R1", "response single pulse",
        rsp_valid, 0);
  endtask

  function automatic int rnd_fld();
    int v = int'($urandom_range(0, 9));
    return (v == 9) ? 15 : (v % 4);
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // r1_ reset state
    chk(mem_cs_n === 1 && mem_adv_n === 1 && mem_oe_n === 1 && mem_we_n === 1 &&
        mem_addr_oe === 0 && mem_dout_oe === 0 && rsp_valid === 0 && req_ready === 0 + 1,
        "R1", "strobes idle in reset", {mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n}, 4'hF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_cs_n === 1 && req_ready === 1 && rsp_valid === 0, "R1", "idle after reset",
        {mem_cs_n, req_ready, rsp_valid}, 3'b110);
    // directed: all-zero fields (R11)
    do_access(1'b0, 1'b0, 1'b0, 0, 0, 0, 0, 0, 0, 24'h000123, 16'h0);
    do_access(1'b1, 1'b0, 1'b0, 0, 0, 0, 0, 0, 0, 24'h000456, 16'hBEEF);
    // directed: maximum fields
    do_access(1'b0, 1'b1, 1'b0, 15, 15, 15, 15, 0, 0, 24'hFFFFFF, 16'h0);
    do_access(1'b1, 1'b1, 1'b1, 15, 0, 0, 0, 15, 15, 24'hABCDEF, 16'h1357);
    // directed: retime ignored in async, honoured in sync (R8)
    do_access(1'b0, 1'b0, 1'b1, 1, 2, 3, 0, 0, 0, 24'h010203, 16'h0);
    do_access(1'b0, 1'b1, 1'b1, 1, 2, 3, 0, 0, 0, 24'h010203, 16'h0);
    do_access(1'b0, 1'b1, 1'b0, 2, 0, 1, 1, 0, 0, 24'h0A0B0C, 16'h0);
    // constrained random
    for (int t = 0; t < 80; t++) begin
      do_access(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                rnd_fld(), rnd_fld(), rnd_fld(), rnd_fld(), rnd_fld(), rnd_fld(),
                AW'($urandom), DW'($urandom));
    end
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule